// File: doc/BRIEF.md
# PCM Port Lock-Phase Output Sequencer

This block supervises two PCM serial audio ports (index 0 and index 1) while the port clock generator powers up and settles. A 4-bit reference-select code is decoded into the port that supplies the reference, whether that reference is the frame sync or the bit clock, and the reference rate as a multiple of the frame rate. The same code picks the length of a settle window. A millisecond tick input counts that window down and stands in for the analog lock.

While power is off, the block drives both data words low and releases every clock pin. During the settle window it holds each data word at an idle code chosen by that port's encoding, and it holds the master port's clocks at fixed levels. Once the window ends, the upstream data words and the generated clocks pass through. It also flags unavailable codes and master/slave setups that are not legal, and it registers the outgoing bit-clock rate.

Top module: `pcm_lock_seq`

## Requirements
- R1: Codes 0..7 select port `code[2]` as reference. With `code[1:0]`=0 the source is frame sync at 1x (`ref_use_sync`=1, `ref_mult`=1). With 1, 2 or 3 the source is bit clock at 16, 32 or 64x.
- R2: Code 11 selects port 0 bit clock at 48x, and code 15 selects port 1 bit clock at 48x. Every other code (8, 9, 10, 12, 13, 14) raises `mode_err`, with `ref_mult`=0.
- R3: Code 1 raises `mode_err` when `fmt_alt[0]`=1, and code 5 raises `mode_err` when `fmt_alt[1]`=1.
- R4: `cfg_err` is 1 exactly when `master[0]` equals `master[1]`.
- R5: While `pwr_en`=0, every `sync_oe` and `bck_oe` bit is 0, both data words are 0 and `lock_done` is 0.
- R6: The settle window is reloaded on the edge where `pwr_en` is first seen at 1, and on any edge where the code differs from the previous cycle. It lasts 260 ticks for codes 0 and 4 and 40 ticks for all other codes. `lock_done` rises one cycle after the edge that takes the final tick. A tick on the reload edge is ignored.
- R7: While powered and `lock_done`=0, each port's data word is its idle code. Encoding 0 (linear) and 3 give 0x0000, encoding 1 (A-law) gives 0x00D5, and encoding 2 (mu-law) gives 0x00FF.
- R8: During the settle window the master port enables both clock pins, drives the bit clock 0 and drives the frame sync equal to its `i2s` bit. A slave port keeps both enables at 0 at all times.
- R9: After `lock_done`, each data word equals its upstream word, and the master port drives its generated sync and bit clock with both enables at 1.
- R10: `bck_out_fs` is 16 after reset. It follows `bck_rate_sel` one cycle later: 16 for 0 and 32 for 1.
- R11: While `mode_err` is 1, `lock_done` stays 0 no matter how many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Port power enable |
| ms_tick | input | 1 | One-cycle millisecond tick |
| ref_code | input | 4 | Reference-select code |
| bck_rate_sel | input | 1 | Outgoing bit-clock rate select |
| master | input | 2 | Per-port master (1) / slave (0) |
| fmt_alt | input | 2 | Per-port format bit that excludes codes 1/5 |
| i2s | input | 2 | Per-port I2S format flag |
| enc | input | 2x2 | Per-port encoding |
| word_in | input | 2xDATA_W | Upstream data words |
| gen_sync | input | 2 | Generated frame syncs |
| gen_bck | input | 2 | Generated bit clocks |
| word_out | output | 2xDATA_W | Data words to the shifters |
| sync_o | output | 2 | Frame sync pin values |
| sync_oe | output | 2 | Frame sync pin enables |
| bck_o | output | 2 | Bit clock pin values |
| bck_oe | output | 2 | Bit clock pin enables |
| lock_done | output | 1 | Settle window complete |
| mode_err | output | 1 | Unavailable reference code |
| cfg_err | output | 1 | Illegal master/slave setup |
| ref_port | output | 1 | Reference port index |
| ref_use_sync | output | 1 | Reference is frame sync |
| ref_mult | output | 7 | Reference rate multiple |
| bck_out_fs | output | 6 | Outgoing bit-clock multiple |

## Verification
The assertions assume that `ms_tick` is a pulse sampled on clock edges, that the reference code is held steady for at least one full cycle whenever it changes, and that the master bits form a legal pair whenever the single-driver property is relied on. The bench drives every input at the falling edge, so each value holds across a whole cycle. Random trials pick exactly one master port and only available codes for the lock runs. Illegal codes and illegal master pairs are applied only in dedicated directed phases.

// File: rtl/pcm_lock_pkg.sv
package pcm_lock_pkg;

    typedef enum logic [1:0] {
        ENC_LINEAR = 2'd0,
        ENC_ALAW   = 2'd1,
        ENC_MULAW  = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_e;

    typedef struct packed {
        logic       port;
        logic       use_sync;
        logic [6:0] mult;
        logic       err;
    } ref_sel_t;

    function automatic logic [15:0] idle_code(input logic [1:0] e);
        case (e)
            ENC_ALAW:  idle_code = 16'h00D5;
            ENC_MULAW: idle_code = 16'h00FF;
            default:   idle_code = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/pcm_ref_decode.sv
module pcm_ref_decode
    import pcm_lock_pkg::*;
(
    input  logic [3:0] code,
    input  logic [1:0] fmt_alt,
    output ref_sel_t   sel
);
    always_comb begin
        sel = '0;
        if (!code[3]) begin
            sel.port = code[2];
            case (code[1:0])
                2'd0: begin sel.use_sync = 1'b1; sel.mult = 7'd1; end
                2'd1: sel.mult = 7'd16;
                2'd2: sel.mult = 7'd32;
                default: sel.mult = 7'd64;
            endcase
            if (code[1:0] == 2'd1 && fmt_alt[code[2]]) begin
                sel.err  = 1'b1;
                sel.mult = 7'd0;
            end
        end else if (code[1:0] == 2'd3) begin
            sel.port = code[2];
            sel.mult = 7'd48;
        end else begin
            sel.err = 1'b1;
        end
    end
endmodule

// File: rtl/pcm_lock_timer.sv
module pcm_lock_timer #(
    parameter int TICKS_SYNC = 260,
    parameter int TICKS_BCK  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en,
    input  logic       ms_tick,
    input  logic [3:0] code,
    input  logic       long_wait,
    input  logic       mode_err,
    output logic       lock_done
);
    localparam int TMAX  = (TICKS_SYNC > TICKS_BCK) ? TICKS_SYNC : TICKS_BCK;
    localparam int CNT_W = $clog2(TMAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             pwr;
        logic [3:0]       code;
    } tmr_t;

    tmr_t st_d, st_q;
    logic restart;

    always_comb begin
        st_d      = st_q;
        st_d.pwr  = pwr_en;
        st_d.code = code;
        restart   = pwr_en && (!st_q.pwr || code != st_q.code);
        if (!pwr_en) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (restart) begin
            st_d.cnt  = long_wait ? CNT_W'(TICKS_SYNC) : CNT_W'(TICKS_BCK);
            st_d.done = 1'b0;
        end else begin
            if (ms_tick && st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            st_d.done = (st_q.done || st_q.cnt == '0) && !mode_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_done = st_q.done;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(TMAX));
    p_rise_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !st_q.pwr) |=> (!st_q.done && st_q.cnt != '0));
    p_off_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !st_q.done);
    p_err_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> !st_q.done);
endmodule

// File: rtl/pcm_port_out.sv
module pcm_port_out
    import pcm_lock_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              settled,
    input  logic              is_master,
    input  logic              is_i2s,
    input  logic [1:0]        enc,
    input  logic [DATA_W-1:0] word_in,
    input  logic              gen_sync,
    input  logic              gen_bck,
    output logic [DATA_W-1:0] word_out,
    output logic              sync_o,
    output logic              sync_oe,
    output logic              bck_o,
    output logic              bck_oe
);
    logic waiting;
    assign waiting = pwr_en && !settled;

    always_comb begin
        word_out = '0;
        sync_o   = 1'b0;
        sync_oe  = 1'b0;
        bck_o    = 1'b0;
        bck_oe   = 1'b0;
        if (pwr_en) begin
            word_out = waiting ? DATA_W'(idle_code(enc)) : word_in;
            if (is_master) begin
                sync_oe = 1'b1;
                bck_oe  = 1'b1;
                sync_o  = waiting ? is_i2s : gen_sync;
                bck_o   = waiting ? 1'b0 : gen_bck;
            end
        end
    end

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (!sync_oe && !bck_oe));
    p_wait_bck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && is_master) |-> (bck_oe && !bck_o));
    p_off_word_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (word_out == '0));
endmodule

// File: rtl/pcm_lock_seq.sv
module pcm_lock_seq
    import pcm_lock_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NPORT      = 2,
    parameter int TICKS_SYNC = 260,
    parameter int TICKS_BCK  = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pwr_en,
    input  logic                         ms_tick,
    input  logic [3:0]                   ref_code,
    input  logic                         bck_rate_sel,
    input  logic [NPORT-1:0]             master,
    input  logic [NPORT-1:0]             fmt_alt,
    input  logic [NPORT-1:0]             i2s,
    input  logic [NPORT-1:0][1:0]        enc,
    input  logic [NPORT-1:0][DATA_W-1:0] word_in,
    input  logic [NPORT-1:0]             gen_sync,
    input  logic [NPORT-1:0]             gen_bck,
    output logic [NPORT-1:0][DATA_W-1:0] word_out,
    output logic [NPORT-1:0]             sync_o,
    output logic [NPORT-1:0]             sync_oe,
    output logic [NPORT-1:0]             bck_o,
    output logic [NPORT-1:0]             bck_oe,
    output logic                         lock_done,
    output logic                         mode_err,
    output logic                         cfg_err,
    output logic                         ref_port,
    output logic                         ref_use_sync,
    output logic [6:0]                   ref_mult,
    output logic [5:0]                   bck_out_fs
);
    localparam logic [5:0] FS_SLOW = 6'd16;
    localparam logic [5:0] FS_FAST = 6'd32;

    ref_sel_t sel;
    logic     rate_d, rate_q;

    pcm_ref_decode u_decode (
        .code    (ref_code),
        .fmt_alt (fmt_alt),
        .sel     (sel)
    );

    pcm_lock_timer #(
        .TICKS_SYNC (TICKS_SYNC),
        .TICKS_BCK  (TICKS_BCK)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .ms_tick   (ms_tick),
        .code      (ref_code),
        .long_wait (sel.use_sync),
        .mode_err  (sel.err),
        .lock_done (lock_done)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pcm_port_out #(.DATA_W(DATA_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_en    (pwr_en),
            .settled   (lock_done),
            .is_master (master[p]),
            .is_i2s    (i2s[p]),
            .enc       (enc[p]),
            .word_in   (word_in[p]),
            .gen_sync  (gen_sync[p]),
            .gen_bck   (gen_bck[p]),
            .word_out  (word_out[p]),
            .sync_o    (sync_o[p]),
            .sync_oe   (sync_oe[p]),
            .bck_o     (bck_o[p]),
            .bck_oe    (bck_oe[p])
        );
    end

    always_comb begin
        rate_d = bck_rate_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
        end else begin
            rate_q <= rate_d;
        end
    end

    assign bck_out_fs   = rate_q ? FS_FAST : FS_SLOW;
    assign cfg_err      = (master == '0) || (master == '1);
    assign mode_err     = sel.err;
    assign ref_port     = sel.port;
    assign ref_use_sync = sel.use_sync;
    assign ref_mult     = sel.mult;

    p_single_driver_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_err |-> ($countones(bck_oe) <= 1));
    p_rate_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bck_rate_sel |=> (bck_out_fs == FS_FAST));
    p_off_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (sync_oe == '0 && bck_oe == '0));
    p_pass_after_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && lock_done) |-> (word_out == word_in));
endmodule

// File: tb/test_pcm_lock_seq.sv
module test_pcm_lock_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0, pwr_en = 0, ms_tick = 0, bck_rate_sel = 0;
    logic [3:0] ref_code = 0;
    logic [1:0] master = 2'b01, fmt_alt = 0, i2s = 0, gen_sync = 0, gen_bck = 0;
    logic [1:0][1:0] enc = '0;
    logic [1:0][DW-1:0] word_in = '0;
    logic [1:0][DW-1:0] word_out;
    logic [1:0] sync_o, sync_oe, bck_o, bck_oe;
    logic lock_done, mode_err, cfg_err, ref_port, ref_use_sync;
    logic [6:0] ref_mult;
    logic [5:0] bck_out_fs;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_lock_seq i_pcm_lock_seq (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] e_mult(logic [3:0] c, logic [1:0] fa);
        if (e_err(c, fa)) return 7'd0;
        if (c == 11 || c == 15) return 7'd48;
        case (c[1:0])
            2'd0: return 7'd1;
            2'd1: return 7'd16;
            2'd2: return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    function automatic bit e_err(logic [3:0] c, logic [1:0] fa);
        if (c == 11 || c == 15) return 0;
        if (c > 7) return 1;
        if (c == 1 && fa[0]) return 1;
        if (c == 5 && fa[1]) return 1;
        return 0;
    endfunction

    function automatic int e_len(logic [3:0] c);
        return (c == 0 || c == 4) ? 260 : 40;
    endfunction

    function automatic logic [15:0] e_idle(logic [1:0] e);
        return (e == 1) ? 16'h00D5 : (e == 2) ? 16'h00FF : 16'h0000;
    endfunction

    // ph: 0 power off, 1 settle window, 2 locked
    task automatic check_ports(int ph, string req);
        word_in[0] = DW'($urandom);
        word_in[1] = DW'($urandom);
        gen_sync = 2'($urandom);
        gen_bck = 2'($urandom);
        #1;
        for (int p = 0; p < 2; p++) begin
            logic [15:0] ew;
            logic [3:0] ec;
            ew = (ph == 0) ? 16'h0 : (ph == 1) ? e_idle(enc[p]) : word_in[p];
            chk({req, " word"}, word_out[p], ew);
            if (ph == 0 || !master[p]) begin
                ec = 4'b0000;
                chk({req, " clk"}, {sync_oe[p], bck_oe[p], 2'b00}, ec);
            end else begin
                ec = {2'b11, (ph == 1) ? i2s[p] : gen_sync[p], (ph == 1) ? 1'b0 : gen_bck[p]};
                chk({req, " clk"}, {sync_oe[p], bck_oe[p], sync_o[p], bck_o[p]}, ec);
            end
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1;
        end
        @(negedge clk) ms_tick = 0;
        #1;
    endtask

    task automatic power_on(logic [3:0] c);
        @(negedge clk);
        pwr_en = 1;
        ref_code = c;
        ms_tick = 1;  // tick on the reload edge must be ignored (R6)
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R5, R10)
        chk("R10 reset rate", bck_out_fs, 16);
        chk("R5 reset done", lock_done, 0);
        check_ports(0, "R5");

        // decode sweep (R1, R2, R3)
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 4; f++) begin
                ref_code = 4'(c);
                fmt_alt = 2'(f);
                #1;
                chk($sformatf("R2/R3 err code %0d", c), mode_err, e_err(4'(c), 2'(f)));
                chk($sformatf("R1/R2 mult code %0d", c), ref_mult, e_mult(4'(c), 2'(f)));
                if (!e_err(4'(c), 2'(f))) begin
                    chk("R1 port", ref_port, c[2]);
                    chk("R1 sync", ref_use_sync, (c == 0 || c == 4));
                end
            end
        end
        fmt_alt = 0;

        // master/slave legality (R4)
        for (int m = 0; m < 4; m++) begin
            master = 2'(m);
            #1;
            chk("R4 cfg", cfg_err, (m == 0 || m == 3));
        end
        master = 2'b01;

        // rate select (R10)
        @(negedge clk) bck_rate_sel = 1;
        #1 chk("R10 not yet", bck_out_fs, 16);
        @(negedge clk) #1 chk("R10 fast", bck_out_fs, 32);
        @(negedge clk) bck_rate_sel = 0;
        @(negedge clk) #1 chk("R10 slow", bck_out_fs, 16);

        // long window boundary (R6, R7, R8)
        enc = {2'd2, 2'd1};
        i2s = 2'b01;
        power_on(4'd0);
        @(negedge clk) ms_tick = 0;
        check_ports(1, "R7/R8");
        ticks(259);
        chk("R6 one tick left", lock_done, 0);
        ticks(1);
        chk("R6 last tick pending", lock_done, 0);
        @(negedge clk) #1 chk("R6 locked 260", lock_done, 1);
        check_ports(2, "R9");
        @(negedge clk) pwr_en = 0;
        #1 check_ports(0, "R5 off");
        chk("R5 done cleared", lock_done, 1);  // cleared one edge later
        @(negedge clk) #1 chk("R5 done low", lock_done, 0);

        // code change restarts (R6)
        power_on(4'd1);
        @(negedge clk) ms_tick = 0;
        ticks(30);
        @(negedge clk) ref_code = 4'd2;
        ticks(39);
        chk("R6 restart holds", lock_done, 0);
        ticks(1);
        @(negedge clk) #1 chk("R6 restart lock", lock_done, 1);
        @(negedge clk) pwr_en = 0;

        // unavailable code never locks (R11)
        power_on(4'd9);
        ticks(300);
        chk("R11 no lock", lock_done, 0);
        check_ports(1, "R11 idle");
        @(negedge clk) pwr_en = 0;

        // random trials (R6, R7, R8, R9)
        for (int t = 0; t < 24; t++) begin
            logic [3:0] c;
            int sel;
            sel = $urandom_range(0, 9);
            c = (sel < 8) ? 4'(sel) : (sel == 8) ? 4'd11 : 4'd15;
            master = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
            i2s = 2'($urandom);
            enc = {2'($urandom), 2'($urandom)};
            power_on(c);
            @(negedge clk) ms_tick = 0;
            check_ports(1, "R7/R8 rand");
            ticks(e_len(c));
            chk("R6 rand pending", lock_done, 0);
            @(negedge clk) #1 chk("R6 rand lock", lock_done, 1);
            check_ports(2, "R9 rand");
            @(negedge clk) pwr_en = 0;
            check_ports(0, "R5 rand");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule